// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block joins two 8-bit tri-state ports, called A and B. Each transfer direction has a storage register of its own. The A-to-B register loads the A port when its capture strobe rises. The B-to-A register loads the B port when a second, independent strobe rises. Neither capture depends on the select or enable inputs.

A per-direction select chooses what the far port is driven with: the live value of the opposite port, or the contents of that direction's register. Data is never inverted in either direction.

Each port is modelled as three signals: a resolved input, an output value and an output enable. The surrounding logic or a testbench resolves the actual bus from these and from any external drivers.

Two enables decide which ports the block drives. The B driver has an active-high enable; the A driver has an active-low enable. When both drivers are on and both selects are live, the two ports reinforce each other. This is modelled by a hold register that follows whatever an external driver forces onto either bus. It keeps the last value once all external drivers let go, so no combinational loop through the block is ever formed. Capture strobes are sampled on the system clock, and all timing is counted in cycles of that clock.

Top module: `dual_path_xcvr`

## Requirements
- R1: With only one port driven and its select live, the driven port shows the other port's resolved value in the same cycle, bit for bit and uninverted (B output equals A input; A output equals B input).
- R2: A clock cycle in which `ab_cap` is 1 after being 0 in the previous cycle loads the resolved A input into the A-to-B register, whatever the selects and enables are. The new value appears on the B output from the next cycle while `ab_stored` is 1.
- R3: A clock cycle in which `ba_cap` is 1 after being 0 in the previous cycle loads the resolved B input into the B-to-A register, whatever the selects and enables are. The new value appears on the A output from the next cycle while `ba_stored` is 1.
- R4: With a select at 1 (stored), the driven port shows its register, and that value stays unchanged while the strobe is held at any constant level.
- R5: `b_oe` equals `b_drive_en`, and `a_oe` is the inverse of `a_drive_n`. With both drivers off, neither port is driven, yet both registers still capture.
- R6: With both ports driven and both selects stored, the A output shows the B-to-A register and the B output shows the A-to-B register.
- R7: With both ports driven, one select live and the other stored, the live-selected port shows what the stored-selected port is driving.
- R8: With both ports driven and both selects live, A and B outputs are equal. A value forced externally onto either bus appears on both outputs one cycle later and is kept after the external driver releases.
- R9: On entry into the mutual-hold mode, both outputs show the bus value that was live in the cycle before entry.
- R10: With `HAS_RESET` = 1, a cycle with `rst` = 1 clears both registers and the hold value to zero.
- R11: A capture takes the resolved port value even while the block itself drives that port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset of the data state, active high |
| ab_cap | input | 1 | A-to-B capture strobe, acts on its 0-to-1 change |
| ba_cap | input | 1 | B-to-A capture strobe, acts on its 0-to-1 change |
| ab_stored | input | 1 | 1: B shows the A-to-B register; 0: live A data |
| ba_stored | input | 1 | 1: A shows the B-to-A register; 0: live B data |
| a_drive_n | input | 1 | A port driver enable, active low |
| b_drive_en | input | 1 | B port driver enable, active high |
| a_in | input | W | Resolved A bus value |
| a_out | output | W | Value the block places on the A bus |
| a_oe | output | 1 | A bus output enable |
| b_in | input | W | Resolved B bus value |
| b_out | output | W | Value the block places on the B bus |
| b_oe | output | 1 | B bus output enable |

## Verification
The bench sweeps all sixteen combinations of the two enables and two selects. In each combination it steps eight cycles with changing bus data and strobe patterns. Running live modes against stored modes separates pass-through from register readout. Holding a strobe high for several cycles separates edge capture from level capture.

Directed sequences cover the remaining cases: forcing a value onto one bus in the mutual-hold mode and then releasing it, entering that mode from single-direction drive, capturing a port the block drives, and reading both registers straight after reset. These separate the hold register's follow-and-keep behaviour from plain pass-through.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

   typedef struct packed {
      logic a_en;
      logic b_en;
      logic ab_st;
      logic ba_st;
   } xcvr_ctl_t;

   function automatic logic ctl_is_loop(xcvr_ctl_t c);
      return c.a_en & c.b_en & ~c.ab_st & ~c.ba_st;
   endfunction

endpackage

// File: rtl/xcvr_cap_reg.sv
module xcvr_cap_reg #(
   parameter int W = 8,
   parameter bit HAS_RESET = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         cap,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic cap_d;
   logic fire;

   always_ff @(posedge clk) cap_d <= cap;

   assign fire = cap & ~cap_d;

   generate
      if (HAS_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst)       q <= '0;
            else if (fire) q <= d;
         end
      end else begin : g_norst
         logic unused_rst;
         assign unused_rst = rst;
         always_ff @(posedge clk) begin
            if (fire) q <= d;
         end
      end
   endgenerate

endmodule

// File: rtl/xcvr_loop_hold.sv
module xcvr_loop_hold #(
   parameter int W = 8,
   parameter bit HAS_RESET = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         loop,
   input  logic         a_oe,
   input  logic [W-1:0] a_in,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] q
);

   logic [W-1:0] nxt;

   always_comb begin
      if (loop) begin
         if (a_in != q)      nxt = a_in;
         else if (b_in != q) nxt = b_in;
         else                nxt = q;
      end else begin
         nxt = a_oe ? b_in : a_in;
      end
   end

   generate
      if (HAS_RESET) begin : g_rst
         always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= nxt;
         end
      end else begin : g_norst
         logic unused_rst;
         assign unused_rst = rst;
         always_ff @(posedge clk) q <= nxt;
      end
   endgenerate

endmodule

// File: rtl/xcvr_src_mux.sv
module xcvr_src_mux #(
   parameter int W = 8
) (
   input  logic         stored,
   input  logic         loop,
   input  logic         far_oe,
   input  logic [W-1:0] own_q,
   input  logic [W-1:0] hold_q,
   input  logic [W-1:0] far_q,
   input  logic [W-1:0] far_in,
   output logic [W-1:0] val
);

   always_comb begin
      if (stored)      val = own_q;
      else if (loop)   val = hold_q;
      else if (far_oe) val = far_q;
      else             val = far_in;
   end

endmodule

// File: rtl/dual_path_xcvr.sv
module dual_path_xcvr #(
   parameter int W = 8,
   parameter bit HAS_RESET = 1'b1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ab_cap,
   input  logic         ba_cap,
   input  logic         ab_stored,
   input  logic         ba_stored,
   input  logic         a_drive_n,
   input  logic         b_drive_en,
   input  logic [W-1:0] a_in,
   output logic [W-1:0] a_out,
   output logic         a_oe,
   input  logic [W-1:0] b_in,
   output logic [W-1:0] b_out,
   output logic         b_oe
);
   import xcvr_pkg::*;

   generate
      if (W < 1) begin : g_bad_width
         $error("dual_path_xcvr: W must be at least 1");
      end
   endgenerate

   xcvr_ctl_t    ctl;
   logic         loop_mode;
   logic [W-1:0] ab_q;
   logic [W-1:0] ba_q;
   logic [W-1:0] hold_q;

   assign ctl.a_en  = ~a_drive_n;
   assign ctl.b_en  = b_drive_en;
   assign ctl.ab_st = ab_stored;
   assign ctl.ba_st = ba_stored;
   assign loop_mode = ctl_is_loop(ctl);

   xcvr_cap_reg #(.W(W), .HAS_RESET(HAS_RESET)) u_ab_reg (
      .clk (clk), .rst (rst), .cap (ab_cap), .d (a_in), .q (ab_q)
   );

   xcvr_cap_reg #(.W(W), .HAS_RESET(HAS_RESET)) u_ba_reg (
      .clk (clk), .rst (rst), .cap (ba_cap), .d (b_in), .q (ba_q)
   );

   xcvr_loop_hold #(.W(W), .HAS_RESET(HAS_RESET)) u_hold (
      .clk  (clk),
      .rst  (rst),
      .loop (loop_mode),
      .a_oe (ctl.a_en),
      .a_in (a_in),
      .b_in (b_in),
      .q    (hold_q)
   );

   xcvr_src_mux #(.W(W)) u_b_mux (
      .stored (ctl.ab_st),
      .loop   (loop_mode),
      .far_oe (ctl.a_en),
      .own_q  (ab_q),
      .hold_q (hold_q),
      .far_q  (ba_q),
      .far_in (a_in),
      .val    (b_out)
   );

   xcvr_src_mux #(.W(W)) u_a_mux (
      .stored (ctl.ba_st),
      .loop   (loop_mode),
      .far_oe (ctl.b_en),
      .own_q  (ba_q),
      .hold_q (hold_q),
      .far_q  (ab_q),
      .far_in (b_in),
      .val    (a_out)
   );

   assign a_oe = ctl.a_en;
   assign b_oe = ctl.b_en;

endmodule

// File: rtl/dual_path_xcvr_chk.sv
module dual_path_xcvr_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst,
   input logic         ab_cap,
   input logic         ba_cap,
   input logic         ab_stored,
   input logic         ba_stored,
   input logic         a_drive_n,
   input logic         b_drive_en,
   input logic [W-1:0] a_in,
   input logic [W-1:0] a_out,
   input logic         a_oe,
   input logic [W-1:0] b_in,
   input logic [W-1:0] b_out,
   input logic         b_oe
);

   logic loop_m;
   assign loop_m = a_oe & b_oe & ~ab_stored & ~ba_stored;

   // R2
   ab_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (ab_cap && !$past(ab_cap)) |=> (!ab_stored || b_out == $past(a_in)));

   // R3
   ba_capture_chk: assert property (@(posedge clk) disable iff (rst)
      (ba_cap && !$past(ba_cap)) |=> (!ba_stored || a_out == $past(b_in)));

   // R4
   ab_stored_steady_chk: assert property (@(posedge clk) disable iff (rst)
      (ab_stored && !(ab_cap && !$past(ab_cap))) |=> (!ab_stored || $stable(b_out)));

   // R5
   oe_polarity_chk: assert property (@(posedge clk) disable iff (rst)
      (a_oe != a_drive_n) && (b_oe == b_drive_en));

   // R8
   loop_equal_chk: assert property (@(posedge clk) disable iff (rst)
      loop_m |-> (a_out == b_out));

   // R8
   loop_follow_chk: assert property (@(posedge clk) disable iff (rst)
      (loop_m && a_in != a_out) |=> (!loop_m || b_out == $past(a_in)));

   // R8
   loop_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (loop_m && a_in == a_out && b_in == b_out) |=> (!loop_m || $stable(a_out)));

endmodule

bind dual_path_xcvr dual_path_xcvr_chk #(.W(W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .ab_cap     (ab_cap),
   .ba_cap     (ba_cap),
   .ab_stored  (ab_stored),
   .ba_stored  (ba_stored),
   .a_drive_n  (a_drive_n),
   .b_drive_en (b_drive_en),
   .a_in       (a_in),
   .a_out      (a_out),
   .a_oe       (a_oe),
   .b_in       (b_in),
   .b_out      (b_out),
   .b_oe       (b_oe)
);

// File: tb/dual_path_xcvr_tb.sv
module dual_path_xcvr_tb;
   localparam int W = 8;
   localparam time PERIOD = 10ns;
   localparam int WATCHDOG_CYC = 200000;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic ab_cap = 1'b0, ba_cap = 1'b0;
   logic ab_stored = 1'b0, ba_stored = 1'b0;
   logic a_drive_n = 1'b1, b_drive_en = 1'b0;
   logic ext_a_en = 1'b0, ext_b_en = 1'b0;
   logic [W-1:0] ext_a = '0, ext_b = '0;
   logic [W-1:0] a_keep = '0, b_keep = '0;
   logic [W-1:0] a_bus, b_bus, a_out, b_out;
   logic a_oe, b_oe;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench-side model state
   logic [W-1:0] m_ab = '0, m_ba = '0, m_hold = '0;
   logic m_pab = 1'b0, m_pba = 1'b0;

   always #(PERIOD/2) clk = ~clk;

   assign a_bus = ext_a_en ? ext_a : (a_oe ? a_out : a_keep);
   assign b_bus = ext_b_en ? ext_b : (b_oe ? b_out : b_keep);

   always @(posedge clk) begin
      a_keep <= a_bus;
      b_keep <= b_bus;
   end

   dual_path_xcvr #(.W(W), .HAS_RESET(1'b1)) u_dut (
      .clk(clk), .rst(rst), .ab_cap(ab_cap), .ba_cap(ba_cap),
      .ab_stored(ab_stored), .ba_stored(ba_stored),
      .a_drive_n(a_drive_n), .b_drive_en(b_drive_en),
      .a_in(a_bus), .a_out(a_out), .a_oe(a_oe),
      .b_in(b_bus), .b_out(b_out), .b_oe(b_oe)
   );

   task automatic chk(input string req, input string what,
                      input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   // one cycle: check outputs mid-cycle, then advance the model at the edge
   task automatic step(input string req);
      logic en_a, en_b, lp;
      logic [W-1:0] ea, eb, pa, pb;
      #1;
      en_a = ~a_drive_n;
      en_b = b_drive_en;
      lp = en_a & en_b & ~ab_stored & ~ba_stored;
      chk("R5", "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, en_a});
      chk("R5", "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, en_b});
      if ((ext_a_en && en_a && !lp) || (ext_b_en && en_b && !lp)) begin
         checks++; errors++;
         $display("FAIL R5 contention actual=%b%b expected=00", ext_a_en & en_a, ext_b_en & en_b);
      end
      eb = ab_stored ? m_ab : lp ? m_hold : en_a ? m_ba : a_bus;
      ea = ba_stored ? m_ba : lp ? m_hold : en_b ? m_ab : b_bus;
      if (en_b) chk(req, "b_out", b_out, eb);
      if (en_a) chk(req, "a_out", a_out, ea);
      pa = a_bus; pb = b_bus;
      @(posedge clk);
      if (rst) begin
         m_ab = '0; m_ba = '0; m_hold = '0;
      end else begin
         if (ab_cap && !m_pab) m_ab = pa;
         if (ba_cap && !m_pba) m_ba = pb;
         if (lp) m_hold = (pa != m_hold) ? pa : (pb != m_hold) ? pb : m_hold;
         else    m_hold = en_a ? pb : pa;
      end
      m_pab = ab_cap; m_pba = ba_cap;
      @(negedge clk);
   endtask

   task automatic set_mode(input logic an, input logic be, input logic as, input logic bs);
      a_drive_n = an; b_drive_en = be; ab_stored = as; ba_stored = bs;
   endtask

   initial begin
      repeat (WATCHDOG_CYC) @(posedge clk);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      @(negedge clk);
      step("R10"); step("R10");
      rst = 1'b0;
      // R10: both stored, both driven, no capture yet -> zeros
      set_mode(1'b0, 1'b1, 1'b1, 1'b1);
      #1;
      chk("R10", "a_out after reset", a_out, '0);
      chk("R10", "b_out after reset", b_out, '0);
      step("R10");

      // R2: capture A while only B driven (stored), value appears next cycle
      set_mode(1'b1, 1'b1, 1'b1, 1'b0);
      ext_a_en = 1'b1; ext_a = 8'hA5;
      ab_cap = 1'b1; step("R2");
      ext_a = 8'h3C; step("R4");
      #1 chk("R2", "b_out holds captured A5", b_out, 8'hA5);
      step("R4");
      ab_cap = 1'b0; step("R4");

      // R3: capture B with both drivers off (R5), read via A in stored mode
      set_mode(1'b1, 1'b0, 1'b0, 1'b1);
      ext_b_en = 1'b1; ext_b = 8'h5A;
      ba_cap = 1'b1; step("R3");
      ba_cap = 1'b0; ext_b = 8'h00; step("R5");
      ext_a_en = 1'b0;
      set_mode(1'b0, 1'b0, 1'b0, 1'b1);
      #1 chk("R3", "a_out shows captured 5A", a_out, 8'h5A);
      step("R3");

      // R1: live pass-through each way
      set_mode(1'b0, 1'b0, 1'b0, 1'b0); ext_b = 8'hC3; step("R1");
      ext_b_en = 1'b0; ext_a_en = 1'b1; ext_a = 8'h81;
      set_mode(1'b1, 1'b1, 1'b0, 1'b0); step("R1");

      // R6: both driven, both stored
      ext_a_en = 1'b0;
      set_mode(1'b0, 1'b1, 1'b1, 1'b1); step("R6");
      // R11: capture A while block drives A from B-to-A register
      ab_cap = 1'b1; step("R11");
      #1 chk("R11", "b_out equals driven A value", b_out, 8'h5A);
      step("R11");
      ab_cap = 1'b0;
      // R7: B live, A stored
      set_mode(1'b0, 1'b1, 1'b0, 1'b1); step("R7");
      set_mode(1'b0, 1'b1, 1'b1, 1'b0); step("R7");

      // R9: enter loop from B-only drive of live A = 77
      set_mode(1'b1, 1'b1, 1'b0, 1'b0); ext_a_en = 1'b1; ext_a = 8'h77; step("R9");
      ext_a_en = 1'b0;
      set_mode(1'b0, 1'b1, 1'b0, 1'b0);
      #1 chk("R9", "loop entry value", b_out, 8'h77);
      step("R9");
      // R8: force B externally, release, value kept on both ports
      ext_b_en = 1'b1; ext_b = 8'hE1; step("R8");
      ext_b_en = 1'b0; step("R8");
      #1 chk("R8", "a_out after release", a_out, 8'hE1);
      chk("R8", "b_out after release", b_out, 8'hE1);
      step("R8"); step("R8");

      // sweep: all modes, strobe and data patterns
      for (int m = 0; m < 16; m++) begin
         for (int k = 0; k < 8; k++) begin
            logic an, be, lp;
            an = m[0]; be = m[1];
            set_mode(an, be, m[2], m[3]);
            lp = ~an & be & ~m[2] & ~m[3];
            ext_a = 8'(8'h11 * k) ^ 8'(m);
            ext_b = {ext_a[3:0], ext_a[7:4]} ^ 8'h96;
            ext_a_en = lp ? (k == 3) : an;
            ext_b_en = lp ? (k == 5) : ~be;
            ab_cap = k[0]; ba_cap = k[1];
            step(lp ? "R8" : (m[2] | m[3]) ? "R4" : "R1");
         end
      end
      ext_a_en = 1'b0; ext_b_en = 1'b0;

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule